// File: doc/BRIEF.md
# Serial Configuration Register Port for a Scanner Front End

This block is a serial slave that holds the settings of a three-channel scanner front end. The store has eight byte-wide locations: one configuration register, a gain register for each of the red, green and blue channels, an offset register for each channel, and one reserved location. A host reaches it over a framed serial link that has an active-low enable and a serial clock. Data travels either on one bidirectional data pin (three-wire) or on separate input and output pins (four-wire). The host picks the wire mode again on every frame. It does this by the level it applies to a shared mode/output pin while the address is being sent.

The serial pins are sampled in the block's system clock domain. On a rising serial-clock edge the block takes in one input bit. On a falling serial-clock edge it launches one read bit. Every frame has sixteen bit slots in a fixed order: one command bit, three address bits, four unused slots and eight data bits. Address and data are both sent least significant bit first. The select inputs pick which channel's gain and offset values appear on the outputs. The configuration register is decoded into named mode outputs, and its power-down bit overrides all of the other fields. Bidirectional pins are shown as separate input, output and output-enable ports.

Top module: `afe_serial_regs`

## Requirements
- R1: After reset, every register reads back zero, all routed and decoded outputs are zero, and both output enables are low.
- R2: A frame with command bit 0 writes the register. Bit slot 0 is the command, slots 1 to 3 hold address bits 0 to 2, slots 4 to 7 are ignored, and slots 8 to 15 hold data bits 0 to 7. Each slot is taken on a rising serial-clock edge. The new value takes effect only after the rising edge of slot 15.
- R3: A frame with command bit 1 returns the addressed register. Data bit 0 is launched on the falling serial-clock edge that follows slot 7, and each later falling edge launches the next bit, up to bit 7.
- R4: The mode/output pin is sampled on the rising edge of slot 3. If it is low, read data appears on the data pin with sdio_oe high and smo_oe low. If it is high, read data appears on the mode/output pin with smo_oe high and sdio_oe low.
- R5: While sen_n is high, both output enables are low.
- R6: If sen_n rises before slot 15 has been clocked, the frame commits no write.
- R7: Address 0 is the configuration register. Addresses 1, 2 and 3 are the red, green and blue gain registers. Addresses 4, 5 and 6 are the red, green and blue offset registers.
- R8: A write to address 7 changes no register, and a read of address 7 returns 0x00.
- R9: Select values 1, 2 and 3 route the red, green and blue registers to the outputs one clock later. gain_o carries bits 5:0 of the gain register, and offset_o carries the whole offset register.
- R10: While the select value is 0, gain_o and offset_o keep their previous values.
- R11: When configuration bit 7 is 0, the decoded outputs follow the register. span_hi_o is bit 0, cds_mode_o is bit 1, in_route_o is bits 3:2, and mon_off_o is bit 5.
- R12: When configuration bit 7 is 1, pwr_down_o is high and every other decoded configuration output is zero. Readback still returns all eight bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Frame enable, active low |
| sclk | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data in (shared data pin, input side) |
| sdio_o | output | 1 | Read data for the shared data pin in three-wire mode |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| smo_i | input | 1 | Mode/output pin, input side (low = three-wire) |
| smo_o | output | 1 | Read data for the mode/output pin in four-wire mode |
| smo_oe | output | 1 | Drive enable for the mode/output pin |
| sel_i | input | 2 | Channel select: 1 red, 2 green, 3 blue, 0 hold |
| gain_o | output | 6 | Gain code of the selected channel |
| offset_o | output | 8 | Offset code of the selected channel |
| pwr_down_o | output | 1 | Power-down request (configuration bit 7) |
| span_hi_o | output | 1 | Wide input span selected |
| cds_mode_o | output | 1 | Correlated double sampling selected (else sample-and-hold) |
| in_route_o | output | 2 | Input routing: 0 red, 1 green, 2 blue, 3 all three by select |
| mon_off_o | output | 1 | Analog monitor output disabled |

## Verification
A write that commits to the gain register of the channel currently on the select inputs lands in the same clock as the routing stage's refresh of the outputs. The bench provokes this by keeping the select pointed at red while it rewrites the red gain. It expects gain_o to show the new code two clocks after the last rising serial edge, with the code already masked to six bits. The other overlap is a read frame whose wire mode is only settled partway through the address. Here the bench changes the mode pin level between frames and requires each launched data bit to come out on the pin chosen for that frame, with the other pin's enable kept low.

// File: rtl/afe_regs_pkg.sv
package afe_regs_pkg;
   // configuration register field positions (decoded by the register file)
   localparam int CFG_SPAN_BIT  = 0;
   localparam int CFG_CDS_BIT   = 1;
   localparam int CFG_ROUTE_LSB = 2;
   localparam int CFG_ROUTE_W   = 2;
   localparam int CFG_MON_BIT   = 5;
   localparam int CFG_PD_BIT    = 7;

   // fixed frame layout fields
   localparam int CMD_BITS = 1;
   localparam int CMD_READ = 1;
endpackage

// File: rtl/afe_frame_ctrl.sv
module afe_frame_ctrl #(
   parameter int ADDR_W  = 3,
   parameter int DUMMY_W = 4,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sen_n,
   input  logic              sclk,
   input  logic              din,
   input  logic              mode_in,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              dout_o,
   output logic              drive_o,
   output logic              four_o
);
   import afe_regs_pkg::*;

   localparam int DATA_START = CMD_BITS + ADDR_W + DUMMY_W;
   localparam int FRAME_BITS = DATA_START + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   logic             sclk_q;
   logic             rise, fall;
   logic [CNT_W-1:0] cnt_q;
   logic             rw_q;

   assign rise = sclk & ~sclk_q;
   assign fall = ~sclk & sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk;
   end

   // input side: bit counter, command, address, mode and data capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rw_q    <= 1'b0;
         addr_o  <= '0;
         four_o  <= 1'b0;
         wdata_o <= '0;
         wr_en_o <= 1'b0;
      end else begin
         wr_en_o <= 1'b0;
         if (sen_n) begin
            cnt_q <= '0;
         end else if (rise) begin
            if (cnt_q == '0) rw_q <= din;
            for (int i = 0; i < ADDR_W; i++)
               if (cnt_q == CNT_W'(CMD_BITS + i)) addr_o[i] <= din;
            if (cnt_q == CNT_W'(CMD_BITS + ADDR_W - 1)) four_o <= mode_in;
            for (int i = 0; i < DATA_W; i++)
               if (cnt_q == CNT_W'(DATA_START + i)) wdata_o[i] <= din;
            if (cnt_q == CNT_W'(FRAME_BITS - 1) && rw_q != 1'(CMD_READ))
               wr_en_o <= 1'b1;
            if (cnt_q < CNT_W'(FRAME_BITS)) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // output side: read bits launched on falling serial-clock edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_o  <= 1'b0;
         drive_o <= 1'b0;
      end else if (sen_n) begin
         drive_o <= 1'b0;
      end else if (fall && rw_q == 1'(CMD_READ)) begin
         for (int i = 0; i < DATA_W; i++)
            if (cnt_q == CNT_W'(DATA_START + i)) begin
               dout_o  <= rdata_i[i];
               drive_o <= 1'b1;
            end
      end
   end

   // R3
   drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_o) |-> $past(fall) && rw_q);
   // R2
   write_only_on_write_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (rw_q != 1'(CMD_READ)) && !$past(sen_n));
endmodule

// File: rtl/afe_reg_store.sv
module afe_reg_store #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   parameter int NUM_CH = 3,
   parameter int GAIN_W = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   output logic [DATA_W-1:0]             rdata_o,
   output logic [NUM_CH-1:0][GAIN_W-1:0] gain_all_o,
   output logic [NUM_CH-1:0][DATA_W-1:0] off_all_o,
   output logic                          pwr_down_o,
   output logic                          span_hi_o,
   output logic                          cds_mode_o,
   output logic [1:0]                    in_route_o,
   output logic                          mon_off_o
);
   import afe_regs_pkg::*;

   localparam int GAIN_BASE = 1;
   localparam int OFF_BASE  = GAIN_BASE + NUM_CH;
   localparam int NUM_REGS  = OFF_BASE + NUM_CH;

   logic [DATA_W-1:0] cfg_q;
   logic [DATA_W-1:0] gain_q [NUM_CH];
   logic [DATA_W-1:0] off_q  [NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cfg_q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(0))  cfg_q <= wdata_i;
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gain_q[k] <= '0;
            off_q[k]  <= '0;
         end else if (wr_en_i) begin
            if (addr_i == ADDR_W'(GAIN_BASE + k)) gain_q[k] <= wdata_i;
            if (addr_i == ADDR_W'(OFF_BASE + k))  off_q[k]  <= wdata_i;
         end
      end
      assign gain_all_o[k] = gain_q[k][GAIN_W-1:0];
      assign off_all_o[k]  = off_q[k];
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(0)) rdata_o = cfg_q;
      for (int k = 0; k < NUM_CH; k++) begin
         if (addr_i == ADDR_W'(GAIN_BASE + k)) rdata_o = gain_q[k];
         if (addr_i == ADDR_W'(OFF_BASE + k))  rdata_o = off_q[k];
      end
   end

   // power-down overrides every other field
   assign pwr_down_o = cfg_q[CFG_PD_BIT];
   assign span_hi_o  = ~pwr_down_o & cfg_q[CFG_SPAN_BIT];
   assign cds_mode_o = ~pwr_down_o & cfg_q[CFG_CDS_BIT];
   assign mon_off_o  = ~pwr_down_o & cfg_q[CFG_MON_BIT];
   assign in_route_o = pwr_down_o ? 2'b00 : cfg_q[CFG_ROUTE_LSB +: CFG_ROUTE_W];

   // R8
   reserved_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i >= ADDR_W'(NUM_REGS)) |=> $stable(cfg_q) && $stable(gain_q[0]) && $stable(off_q[0]));
   // R7
   cfg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == ADDR_W'(0)) |=> cfg_q == $past(wdata_i));
endmodule

// File: rtl/afe_chan_route.sv
module afe_chan_route #(
   parameter int NUM_CH = 3,
   parameter int GAIN_W = 6,
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SEL_W-1:0]              sel_i,
   input  logic [NUM_CH-1:0][GAIN_W-1:0] gain_all_i,
   input  logic [NUM_CH-1:0][DATA_W-1:0] off_all_i,
   output logic [GAIN_W-1:0]             gain_o,
   output logic [DATA_W-1:0]             offset_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_o   <= '0;
         offset_o <= '0;
      end else begin
         for (int k = 0; k < NUM_CH; k++)
            if (sel_i == SEL_W'(k + 1)) begin
               gain_o   <= gain_all_i[k];
               offset_o <= off_all_i[k];
            end
      end
   end

   // R10
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == '0) |=> $stable(gain_o) && $stable(offset_o));
   // R9
   sel_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_W'(1)) |=> offset_o == $past(off_all_i[0]));
endmodule

// File: rtl/afe_serial_regs.sv
module afe_serial_regs #(
   parameter int ADDR_W  = 3,
   parameter int DUMMY_W = 4,
   parameter int DATA_W  = 8,
   parameter int NUM_CH  = 3,
   parameter int GAIN_W  = 6,
   parameter int SEL_W   = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sen_n,
   input  logic              sclk,
   input  logic              sdio_i,
   output logic              sdio_o,
   output logic              sdio_oe,
   input  logic              smo_i,
   output logic              smo_o,
   output logic              smo_oe,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [GAIN_W-1:0] gain_o,
   output logic [DATA_W-1:0] offset_o,
   output logic              pwr_down_o,
   output logic              span_hi_o,
   output logic              cds_mode_o,
   output logic [1:0]        in_route_o,
   output logic              mon_off_o
);
   if (1 + 2 * NUM_CH > (1 << ADDR_W)) begin : g_bad_map
      $error("register map does not fit the address width");
   end
   if (GAIN_W > DATA_W || DATA_W < 8) begin : g_bad_width
      $error("gain or data width out of range");
   end

   logic [ADDR_W-1:0]             addr;
   logic                          wr_en;
   logic [DATA_W-1:0]             wdata, rdata;
   logic                          dout, drive, four;
   logic [NUM_CH-1:0][GAIN_W-1:0] gain_all;
   logic [NUM_CH-1:0][DATA_W-1:0] off_all;

   afe_frame_ctrl #(.ADDR_W(ADDR_W), .DUMMY_W(DUMMY_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .din(sdio_i),
      .mode_in(smo_i), .rdata_i(rdata), .addr_o(addr), .wr_en_o(wr_en),
      .wdata_o(wdata), .dout_o(dout), .drive_o(drive), .four_o(four)
   );

   afe_reg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .GAIN_W(GAIN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .gain_all_o(gain_all), .off_all_o(off_all),
      .pwr_down_o(pwr_down_o), .span_hi_o(span_hi_o), .cds_mode_o(cds_mode_o),
      .in_route_o(in_route_o), .mon_off_o(mon_off_o)
   );

   afe_chan_route #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_route (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .gain_all_i(gain_all),
      .off_all_i(off_all), .gain_o(gain_o), .offset_o(offset_o)
   );

   assign sdio_o  = dout;
   assign smo_o   = dout;
   assign sdio_oe = drive & ~four & ~sen_n;
   assign smo_oe  = drive &  four & ~sen_n;

   // R5
   idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sen_n |-> !sdio_oe && !smo_oe);
   // R4
   one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdio_oe && smo_oe));
endmodule

// File: tb/afe_serial_regs_test.sv
module afe_serial_regs_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sen_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0, smo_i = 1'b0;
   logic [1:0] sel = 2'd0;
   logic sdio_o, sdio_oe, smo_o, smo_oe;
   logic [5:0] gain_o;
   logic [7:0] offset_o;
   logic pwr_down_o, span_hi_o, cds_mode_o, mon_off_o;
   logic [1:0] in_route_o;

   int checks = 0, errors = 0;

   typedef struct { logic [7:0] data; logic four; string req; } exp_t;
   exp_t expq[$];

   always #10 clk = ~clk;

   afe_serial_regs uut (
      .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdio_i(sdio_i),
      .sdio_o(sdio_o), .sdio_oe(sdio_oe), .smo_i(smo_i), .smo_o(smo_o),
      .smo_oe(smo_oe), .sel_i(sel), .gain_o(gain_o), .offset_o(offset_o),
      .pwr_down_o(pwr_down_o), .span_hi_o(span_hi_o), .cds_mode_o(cds_mode_o),
      .in_route_o(in_route_o), .mon_off_o(mon_off_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one frame of nbits slots; data phase bits of a read are sent as 0
   task automatic xfer(logic rw, logic [2:0] addr, logic [7:0] data, logic four, int nbits);
      logic [15:0] frame;
      frame = {data, 4'b0000, addr, rw};
      smo_i = four;
      sen_n = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdio_i = frame[i];
         sclk = 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sen_n = 1'b1;
      smo_i = 1'b0;
      repeat (4) @(negedge clk);
      // R5: drivers released once the frame ends
      check("R5", {sdio_oe, smo_oe}, 2'b00);
   endtask

   task automatic wr(logic [2:0] addr, logic [7:0] data);
      xfer(1'b0, addr, data, 1'b0, 16);
   endtask

   task automatic rd(logic [2:0] addr, logic [7:0] exp, logic four, string req);
      exp_t e;
      e.data = exp; e.four = four; e.req = req;
      expq.push_back(e);
      xfer(1'b1, addr, 8'h00, four, 16);
   endtask

   task automatic set_sel(logic [1:0] s);
      sel = s;
      repeat (2) @(negedge clk);
   endtask

   // monitor: rebuild each read frame from the pins and compare with the queue
   int m_cnt = 0;
   logic m_rw = 1'b0, m_four = 1'b0, m_oebad = 1'b0;
   logic [7:0] m_dat = '0;
   always @(posedge sclk or posedge sen_n) begin
      if (sen_n) begin
         if (m_cnt == 16 && m_rw) begin
            if (expq.size() == 0) begin
               checks++; errors++;
               $display("FAIL R3: unexpected read data %0h expected none", m_dat);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check(e.req, {24'd0, m_dat}, {24'd0, e.data});
               // R4: only the pin chosen for this frame drives
               check("R4", {31'd0, m_oebad}, 32'd0);
            end
         end
         m_cnt = 0;
         m_oebad = 1'b0;
      end else begin
         if (m_cnt == 0) m_rw = sdio_i;
         if (m_cnt == 3) m_four = smo_i;
         if (m_cnt >= 8 && m_cnt < 16) begin
            m_dat[m_cnt-8] = m_four ? smo_o : sdio_o;
            if (m_four ? !(smo_oe && !sdio_oe) : !(sdio_oe && !smo_oe)) m_oebad = 1'b1;
         end
         m_cnt++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {gain_o, offset_o}, 14'd0);
      check("R1", {pwr_down_o, span_hi_o, cds_mode_o, in_route_o, mon_off_o}, 6'd0);
      check("R1", {sdio_oe, smo_oe}, 2'b00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd(3'd0, 8'h00, 1'b0, "R1");
      rd(3'd5, 8'h00, 1'b1, "R1");

      // R11: configuration fields
      wr(3'd0, 8'h2F);
      check("R11", {pwr_down_o, span_hi_o, cds_mode_o, in_route_o, mon_off_o}, 6'b0_1_1_11_1);
      wr(3'd0, 8'h06);
      check("R11", {pwr_down_o, span_hi_o, cds_mode_o, in_route_o, mon_off_o}, 6'b0_0_1_01_0);
      rd(3'd0, 8'h06, 1'b0, "R3");

      // R7: full map written, read back in both wire modes
      wr(3'd1, 8'h15);
      wr(3'd2, 8'h2A);
      wr(3'd3, 8'hFF);
      wr(3'd4, 8'h81);
      wr(3'd5, 8'h7F);
      wr(3'd6, 8'h3C);
      rd(3'd1, 8'h15, 1'b0, "R7");
      rd(3'd2, 8'h2A, 1'b1, "R7");
      rd(3'd3, 8'hFF, 1'b0, "R7");
      rd(3'd4, 8'h81, 1'b1, "R7");
      rd(3'd5, 8'h7F, 1'b0, "R4");
      rd(3'd6, 8'h3C, 1'b1, "R4");

      // R9: routing per select value
      set_sel(2'd1);
      check("R9", {gain_o, offset_o}, {6'h15, 8'h81});
      set_sel(2'd2);
      check("R9", {gain_o, offset_o}, {6'h2A, 8'h7F});
      set_sel(2'd3);
      check("R9", {gain_o, offset_o}, {6'h3F, 8'h3C});
      // R10: select 0 holds the last routed values
      set_sel(2'd0);
      wr(3'd3, 8'h01);
      check("R10", {gain_o, offset_o}, {6'h3F, 8'h3C});

      // R2: write to the channel on the select lands after the last slot
      set_sel(2'd1);
      wr(3'd1, 8'hE7);
      check("R2", {26'd0, gain_o}, {26'd0, 6'h27});
      rd(3'd1, 8'hE7, 1'b0, "R2");

      // R8: reserved address
      wr(3'd7, 8'hAA);
      rd(3'd7, 8'h00, 1'b1, "R8");
      rd(3'd0, 8'h06, 1'b0, "R8");
      check("R8", {gain_o, offset_o}, {6'h27, 8'h81});

      // R6: frame aborted at slot 12 and at slot 15 commit nothing
      xfer(1'b0, 3'd1, 8'h00, 1'b0, 12);
      xfer(1'b0, 3'd4, 8'h00, 1'b0, 15);
      repeat (2) @(negedge clk);
      check("R6", {gain_o, offset_o}, {6'h27, 8'h81});
      rd(3'd1, 8'hE7, 1'b1, "R6");

      // R12: power-down masks the other fields, readback keeps all bits
      wr(3'd0, 8'hAF);
      check("R12", {pwr_down_o, span_hi_o, cds_mode_o, in_route_o, mon_off_o}, 6'b1_0_0_00_0);
      rd(3'd0, 8'hAF, 1'b1, "R12");
      wr(3'd0, 8'h2F);
      check("R12", {pwr_down_o, span_hi_o, cds_mode_o, in_route_o, mon_off_o}, 6'b0_1_1_11_1);

      repeat (4) @(negedge clk);
      check("R3", expq.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule